// File: doc/BRIEF.md
# JPEG Coefficient Run-Length Coder

This block turns one 8x8 block of quantized transform coefficients into JPEG-style entropy symbols. The coefficients arrive in zig-zag order, one per accepted handshake. The first coefficient of each block is coded as its difference from the DC value of the previous block. The other coefficients are coded as AC symbols. Each AC symbol carries the number of zeros that came before it and an adjusted value.

Runs of sixteen zeros become zero-run markers. These markers are held back and sent only when a later nonzero coefficient needs them. A block whose tail is all zeros ends with a single end-of-block marker instead. The output is one symbol per cycle with a kind tag, a run count, a value, a valid strobe and a block-completion strobe. It feeds a Huffman coder, which is not part of this block.

Top module: `rlc_coder`

## Requirements
- R1: The first coefficient of a block gives a DC symbol (kind 0, run 0). Its value is the adjusted 12-bit wrapped difference between that coefficient and the stored DC. The stored DC then becomes the raw coefficient.
- R2: A `dc_clear` pulse, with no DC accepted in the same cycle, sets the stored DC to zero. Reset also sets it to zero.
- R3: Before output, a negative DC difference or AC value has one subtracted, with 12-bit wrap. Zero and positive values pass unchanged. For example, -3 gives -4 and -2048 gives 2047.
- R4: A nonzero coefficient at indices 1..63 gives an AC symbol (kind 1). Its run is the number of zeros since the previous nonzero or ZRL boundary (0..15). Its value is the adjusted coefficient.
- R5: Each complete group of 16 zeros that comes before a nonzero AC coefficient gives one ZRL symbol (kind 2, run 15, value 0). The ZRL symbols are emitted just before that AC symbol.
- R6: If the coefficients from the last nonzero up to index 63 are all zero, a single EOB symbol (kind 3, run 0, value 0) is emitted for index 63. Any pending ZRL symbols are then dropped.
- R7: If coefficient 63 is nonzero, no EOB is emitted. Its AC symbol is the last symbol of the block.
- R8: `out_last` is high exactly once per block, together with the block's final symbol. An accepted coefficient's symbol appears the cycle after the accepting edge, and each symbol is valid for exactly one cycle.
- R9: While a nonzero AC coefficient waits behind pending ZRLs, `in_ready` is low for exactly one cycle per pending ZRL. Symbols leave in order.
- R10: After reset, `out_valid` is low, `in_ready` is high, and the next accepted coefficient is treated as a DC coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_clear | input | 1 | Clears the stored previous-block DC |
| in_valid | input | 1 | Coefficient offered |
| in_ready | output | 1 | Coefficient accepted on this edge when high with in_valid |
| in_coef | input | 12 | Two's complement coefficient, zig-zag order |
| out_valid | output | 1 | Symbol valid strobe |
| out_kind | output | 2 | Symbol kind: 0 DC, 1 AC, 2 ZRL, 3 EOB |
| out_run | output | 4 | Zero run for the symbol |
| out_value | output | 12 | Adjusted value |
| out_last | output | 1 | Final symbol of the block |

## Verification
A wrong coefficient index shows up at the ports within one block. Either a DC symbol appears in the middle of a block, or `out_last` arrives at the wrong place. A wrong zero count shows up as a wrong run on the next AC symbol. A wrong pending-ZRL count shows up as missing or extra ZRL symbols and a wrong number of stall cycles before that AC symbol. A stored DC that is not updated shows up in the DC value of the following block. The bench compares every emitted symbol in order against a model built from the requirements. It also counts the `in_ready` stall cycles in each block.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   typedef enum logic [1:0] {
      SYM_DC  = 2'd0,
      SYM_AC  = 2'd1,
      SYM_ZRL = 2'd2,
      SYM_EOB = 2'd3
   } sym_kind_e;
endpackage

// File: rtl/rlc_sign_adj.sv
module rlc_sign_adj #(
   parameter int COEF_W  = 12,
   parameter bit ADJ_NEG = 1'b1
) (
   input  logic [COEF_W-1:0] raw,
   output logic [COEF_W-1:0] adj
);
   generate
      if (ADJ_NEG) begin : g_ones
         // negative values move down by one: ones-complement magnitude form
         assign adj = raw - {{(COEF_W-1){1'b0}}, raw[COEF_W-1]};
      end else begin : g_pass
         assign adj = raw;
      end
   endgenerate
endmodule

// File: rtl/rlc_dc_pred.sv
module rlc_dc_pred #(
   parameter int COEF_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [COEF_W-1:0] coef,
   output logic [COEF_W-1:0] diff
);
   logic [COEF_W-1:0] prev_dc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_dc <= '0;
      else if (load)   prev_dc <= coef;
      else if (clear)  prev_dc <= '0;
   end

   assign diff = coef - prev_dc;

   p_dc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> (prev_dc == '0));

   p_dc_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prev_dc == $past(coef)));
endmodule

// File: rtl/rlc_run_track.sv
module rlc_run_track #(
   parameter int BLK_LEN = 64,
   parameter int RUN_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             is_zero,
   input  logic             flush,
   output logic             first,
   output logic             last,
   output logic [RUN_W-1:0] zc,
   output logic             pend_any
);
   localparam int IDX_W  = $clog2(BLK_LEN);
   localparam int GROUP  = 1 << RUN_W;
   localparam int PEND_W = $clog2(BLK_LEN / GROUP + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = '1;
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BLK_LEN - 1);

   logic [IDX_W-1:0]  idx;
   logic [PEND_W-1:0] pend;

   assign first    = (idx == '0);
   assign last     = (idx == IDX_END);
   assign pend_any = (pend != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (step)  idx <= last ? '0 : idx + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc   <= '0;
         pend <= '0;
      end else if (step) begin
         if (first || last) begin
            zc   <= '0;
            pend <= '0;
         end else if (is_zero) begin
            if (zc == RUN_MAX) begin
               zc   <= '0;
               pend <= pend + PEND_W'(1);
            end else begin
               zc <= zc + RUN_W'(1);
            end
         end else begin
            zc <= '0;
         end
      end else if (flush) begin
         pend <= pend - PEND_W'(1);
      end
   end

   // a nonzero AC is only taken once every pending ZRL has gone out
   p_no_pend_at_ac_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !is_zero && !first) |-> !pend_any);

   p_pend_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !first && !last && is_zero && zc == RUN_MAX) |=> pend_any);
endmodule

// File: rtl/rlc_coder.sv
module rlc_coder #(
   parameter int COEF_W  = 12,
   parameter int RUN_W   = 4,
   parameter int BLK_LEN = 64,
   parameter bit ADJ_NEG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dc_clear,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [COEF_W-1:0] in_coef,
   output logic              out_valid,
   output logic [1:0]        out_kind,
   output logic [RUN_W-1:0]  out_run,
   output logic [COEF_W-1:0] out_value,
   output logic              out_last
);
   import rlc_pkg::*;

   generate
      if (BLK_LEN < 2) begin : g_bad_len
         $error("rlc_coder: BLK_LEN must be at least 2");
      end
      if (COEF_W < 2) begin : g_bad_w
         $error("rlc_coder: COEF_W must be at least 2");
      end
      if (RUN_W < 1) begin : g_bad_run
         $error("rlc_coder: RUN_W must be at least 1");
      end
   endgenerate

   logic              first, last, pend_any, is_zero, accept, need_flush;
   logic [RUN_W-1:0]  zc;
   logic [COEF_W-1:0] dc_diff, pre_adj, adj_val;

   assign is_zero    = (in_coef == '0);
   assign need_flush = in_valid && !first && !is_zero && pend_any;
   assign in_ready   = !need_flush;
   assign accept     = in_valid && in_ready;

   rlc_run_track #(.BLK_LEN(BLK_LEN), .RUN_W(RUN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .step(accept), .is_zero(is_zero),
      .flush(need_flush), .first(first), .last(last), .zc(zc),
      .pend_any(pend_any)
   );

   rlc_dc_pred #(.COEF_W(COEF_W)) u_dc (
      .clk(clk), .rst_n(rst_n), .clear(dc_clear), .load(accept && first),
      .coef(in_coef), .diff(dc_diff)
   );

   assign pre_adj = first ? dc_diff : in_coef;

   rlc_sign_adj #(.COEF_W(COEF_W), .ADJ_NEG(ADJ_NEG)) u_adj (
      .raw(pre_adj), .adj(adj_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= SYM_DC;
         out_run   <= '0;
         out_value <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= need_flush || (accept && (first || !is_zero || last));
         out_last  <= accept && last;
         out_run   <= '0;
         out_value <= '0;
         if (need_flush) begin
            out_kind <= SYM_ZRL;
            out_run  <= '1;
         end else if (first) begin
            out_kind  <= SYM_DC;
            out_value <= adj_val;
         end else if (!is_zero) begin
            out_kind  <= SYM_AC;
            out_run   <= zc;
            out_value <= adj_val;
         end else begin
            out_kind <= SYM_EOB;
         end
      end
   end

   p_stall_emits_zrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> (out_valid && out_kind == SYM_ZRL));

   p_last_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && (out_kind == SYM_AC || out_kind == SYM_EOB)));

   p_ac_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == SYM_AC) |-> (out_value != '0));

   p_dc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && first) |=> (out_valid && out_kind == SYM_DC && !out_last));
endmodule

// File: tb/tb_rlc_coder.sv
`timescale 1ns/1ps
module tb_rlc_coder;
   logic        clk = 1'b0;
   logic        rst_n, dc_clear, in_valid, in_ready;
   logic [11:0] in_coef;
   logic        out_valid, out_last;
   logic [1:0]  out_kind;
   logic [3:0]  out_run;
   logic [11:0] out_value;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   rlc_coder dut (
      .clk(clk), .rst_n(rst_n), .dc_clear(dc_clear), .in_valid(in_valid),
      .in_ready(in_ready), .in_coef(in_coef), .out_valid(out_valid),
      .out_kind(out_kind), .out_run(out_run), .out_value(out_value),
      .out_last(out_last)
   );

   // case table: dc, pos_a, val_a, pos_b, val_b (pos 0 = unused)
   localparam int NCASE = 6;
   localparam int CASES [NCASE][5] = '{
      '{100,  1,     5,  3,  -3},
      '{ 90,  0,     0,  0,   0},
      '{ -5, 20,     7, 63,  -1},
      '{  0, 17,     1,  0,   0},
      '{  7, 40,  2047,  0,   0},
      '{  7, 63, -2048,  0,   0}
   };

   logic [18:0] exp_q[$];
   logic [18:0] got_q[$];
   logic [11:0] prev_model;
   int          blk [64];
   int          exp_stall, got_stall;

   always @(negedge clk)
      if (rst_n && out_valid) got_q.push_back({out_last, out_kind, out_run, out_value});

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] adj(input logic [11:0] v);
      return v[11] ? v - 12'd1 : v;
   endfunction

   task automatic model_block();
      int zeros = 0;
      int held = 0;
      logic [11:0] c0 = 12'(blk[0]);
      exp_stall = 0;
      exp_q.push_back({1'b0, 2'd0, 4'd0, adj(c0 - prev_model)});
      prev_model = c0;
      for (int i = 1; i < 64; i++) begin
         if (blk[i] == 0) begin
            if (zeros == 15) begin held++; zeros = 0; end
            else zeros++;
            if (i == 63) exp_q.push_back({1'b1, 2'd3, 4'd0, 12'd0});
         end else begin
            for (int k = 0; k < held; k++) exp_q.push_back({1'b0, 2'd2, 4'd15, 12'd0});
            exp_stall += held;
            held = 0;
            exp_q.push_back({(i == 63), 2'd1, 4'(zeros), adj(12'(blk[i]))});
            zeros = 0;
         end
      end
   endtask

   task automatic drive_coefs(input int n, input bit gaps);
      got_stall = 0;
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 5 == 2)) begin
            @(negedge clk); in_valid = 1'b0;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_coef  = 12'(blk[i]);
         forever begin
            bit r;
            #1 r = in_ready;
            if (!r) got_stall++;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
         end
      end
      @(negedge clk); in_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   function automatic string tag_of(input logic [18:0] e);
      if (e[18]) return (e[16:15] == 2'd1) ? "R7/R8" : "R6/R8";
      case (e[16:15])
         2'd0: return "R1";
         2'd1: return e[11] ? "R3/R4" : "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic compare_syms();
      chk(got_q.size() == exp_q.size(), "R8 symbol count", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size(); i++) begin
         if (i < got_q.size())
            chk(got_q[i] == exp_q[i], tag_of(exp_q[i]), got_q[i], exp_q[i]);
      end
      exp_q.delete();
      got_q.delete();
   endtask

   task automatic fill_block(input int dc, input int pa, input int va, input int pb, input int vb);
      for (int i = 0; i < 64; i++) blk[i] = 0;
      blk[0] = dc;
      if (pa != 0) blk[pa] = va;
      if (pb != 0) blk[pb] = vb;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; dc_clear = 1'b0; in_valid = 1'b0; in_coef = '0;
      prev_model = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: idle state after reset
      chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);

      for (int t = 0; t < NCASE; t++) begin
         fill_block(CASES[t][0], CASES[t][1], CASES[t][2], CASES[t][3], CASES[t][4]);
         model_block();
         drive_coefs(64, t[0]);
         compare_syms();
         chk(got_stall == exp_stall, "R9 stall cycles", got_stall, exp_stall);
      end

      // R2: clearing the stored DC makes the next DC symbol the raw value
      @(negedge clk); dc_clear = 1'b1;
      @(negedge clk); dc_clear = 1'b0;
      prev_model = '0;
      fill_block(33, 0, 0, 0, 0);
      model_block();
      drive_coefs(64, 1'b0);
      chk(exp_q.size() > 0 && got_q.size() > 0 && got_q[0][11:0] == 12'd33,
          "R2 dc after clear", got_q.size() > 0 ? int'(got_q[0][11:0]) : -1, 33);
      compare_syms();

      // R10: reset mid-block restarts at the DC position with stored DC zero
      fill_block(50, 2, 9, 0, 0);
      drive_coefs(10, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      got_q.delete();
      prev_model = '0;
      fill_block(12, 0, 0, 5, -1);
      model_block();
      drive_coefs(64, 1'b0);
      chk(got_q.size() > 0 && got_q[0] == {1'b0, 2'd0, 4'd0, 12'd12},
          "R10 dc after reset", got_q.size() > 0 ? int'(got_q[0]) : -1, 12);
      compare_syms();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule